// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block counts activity on a single input pin. In event mode it adds one to a 16-bit counter for every edge of the chosen polarity seen on the pin. In gated mode it adds one for every 64 system clocks during which the pin rests at the chosen level. When the gate closes, it raises an input flag. One polarity bit serves both modes. In event mode it selects which edge is counted. In gated mode it selects the gating level, and therefore the edge that ends the gate.

Software controls the block through a small word-wide register port with three locations: control, counter and flags. Each flag is cleared by writing a one to its bit. Each flag drives its own interrupt output, qualified by an enable bit. Before any edge detection, the pin passes through a two-flop synchroniser. The divide-by-64 prescaler runs only while the block is enabled in gated mode, so the first gated increment comes a fixed time after that mode is entered.

Top module: `pulse_accum`

## Requirements
- R1: Control register (address 0), with bit 6 = enable, bit 5 = mode (0 event, 1 gated), bit 4 = polarity, bits 3:2 = clock select, bit 1 = overflow interrupt enable and bit 0 = input interrupt enable. Bit 7 always reads 0. The clock-select bits read back as written and have no effect on counting.
- R2: After reset, the control register, the counter (address 1) and the flag register (address 2) read 0, and both interrupt outputs are low.
- R3: While enable is 0, the counter keeps its value, no flag is set and the prescaler is held at zero.
- R4: In event mode with polarity 0, each falling pin edge adds one to the counter and sets the input flag. Rising edges do not count.
- R5: In event mode with polarity 1, each rising pin edge adds one to the counter. Falling edges do not count.
- R6: In gated mode with polarity 0, the counter gains exactly 10 in any 640-cycle window in which the pin is high, and nothing while the pin is low. The falling edge that closes the gate sets the input flag.
- R7: In gated mode with polarity 1, the counter gains exactly 10 in any 640-cycle window in which the pin is low, and nothing while the pin is high. The rising edge that closes the gate sets the input flag.
- R8: An increment from 0xFFFF to 0x0000 sets the overflow flag (flag bit 0). The overflow interrupt equals overflow flag AND control bit 1. The edge interrupt equals input flag (flag bit 1) AND control bit 0.
- R9: Writing the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R10: A write to address 1 loads the counter. When the write coincides with an increment, the written value wins.
- R11: On entry into enabled gated mode, the first increment takes effect on the 64th clock edge after the control write. Any exit from that mode restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Asynchronous accumulator input pin |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 flags |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected register (combinational) |
| ovfIrq | output | 1 | Overflow interrupt request |
| edgeIrq | output | 1 | Input-edge interrupt request |

## Verification
If the prescaler phase is wrong, the counter value at address 1 shows it within 64 cycles, because the first gated increment arrives early or late. If the polarity decode is wrong, the counter moves on the wrong edge, or the input flag is set on the wrong edge. Either shows three cycles after the pin changes, which is the synchroniser plus the edge register. If the overflow or clear logic is wrong, the flag register shows it on the cycle after the wrap or the write, and the interrupt pins follow in the same cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  localparam int BIT_EN    = 6;
  localparam int BIT_MODE  = 5;
  localparam int BIT_POL   = 4;
  localparam int BIT_OVFIE = 1;
  localparam int BIT_INIE  = 0;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_IN  = 1;

  typedef struct packed {
    logic incr;
    logic setIn;
    logic loadCnt;
    logic clrOvf;
    logic clrIn;
  } paccStrobe_t;
endpackage

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
#(
  parameter int PRESC_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [6:0]        wrLow,
  output logic [7:0]        ctrlQ,
  output paccStrobe_t       strobe
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinS;
  logic                   prevQ;
  logic                   riseEv;
  logic                   fallEv;
  logic [PRESC_W-1:0]     prescQ;
  logic                   prescRun;
  logic                   tick;
  logic                   gateOpen;
  logic                   enabled;
  logic                   gatedMode;
  logic                   polarity;
  logic                   activeEdge;

  // Synchroniser chain, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= pinS;
  end

  assign riseEv = pinS & ~prevQ;
  assign fallEv = ~pinS & prevQ;

  // Control register; the top bit is never stored
  always_ff @(posedge clk) begin
    if (!rstN)                          ctrlQ <= '0;
    else if (wrEn && addr == ADDR_CTRL) ctrlQ <= {1'b0, wrLow};
  end

  assign enabled   = ctrlQ[BIT_EN];
  assign gatedMode = ctrlQ[BIT_MODE];
  assign polarity  = ctrlQ[BIT_POL];

  // Prescaler runs only when enabled and gated
  assign prescRun = enabled & gatedMode;

  always_ff @(posedge clk) begin
    if (!rstN)         prescQ <= '0;
    else if (prescRun) prescQ <= prescQ + 1'b1;
    else               prescQ <= '0;
  end

  assign tick = prescRun & (&prescQ);

  // polarity 0: gate while high, closes on fall; polarity 1: the mirror
  assign gateOpen   = pinS ^ polarity;
  assign activeEdge = polarity ? riseEv : fallEv;

  always_comb begin
    strobe         = '0;
    strobe.incr    = enabled & (gatedMode ? (tick & gateOpen) : activeEdge);
    strobe.setIn   = enabled & activeEdge;
    strobe.loadCnt = wrEn & (addr == ADDR_CNT);
    strobe.clrOvf  = wrEn & (addr == ADDR_FLAG) & wrLow[FLAG_OVF];
    strobe.clrIn   = wrEn & (addr == ADDR_FLAG) & wrLow[FLAG_IN];
  end
endmodule

// File: rtl/pacc_datapath.sv
module pacc_datapath
  import pacc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  paccStrobe_t      strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             ovfFlag,
  output logic             inFlag
);
  logic wrap;

  assign wrap = strobe.incr & ~strobe.loadCnt & (&cntQ);

  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= wrData;
    else if (strobe.incr)    cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (wrap)          ovfFlag <= 1'b1;
    else if (strobe.clrOvf) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             inFlag <= 1'b0;
    else if (strobe.setIn) inFlag <= 1'b1;
    else if (strobe.clrIn) inFlag <= 1'b0;
  end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              ovfIrq,
  output logic              edgeIrq
);
  localparam int PAD_CTRL = CNT_W - 8;
  localparam int PAD_FLAG = CNT_W - 2;

  logic [7:0]       ctrlQ;
  logic [CNT_W-1:0] cntQ;
  logic             ovfFlag;
  logic             inFlag;
  paccStrobe_t      strobe;

  pacc_ctrl #(.PRESC_W(PRESC_W), .SYNC_STAGES(2)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrLow  (wrData[6:0]),
    .ctrlQ  (ctrlQ),
    .strobe (strobe)
  );

  pacc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .cntQ    (cntQ),
    .ovfFlag (ovfFlag),
    .inFlag  (inFlag)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = {{PAD_CTRL{1'b0}}, ctrlQ};
      ADDR_CNT:  rdData = cntQ;
      ADDR_FLAG: rdData = {{PAD_FLAG{1'b0}}, inFlag, ovfFlag};
      default:   rdData = '0;
    endcase
  end

  assign ovfIrq  = ovfFlag & ctrlQ[BIT_OVFIE];
  assign edgeIrq = inFlag & ctrlQ[BIT_INIE];
endmodule

// File: rtl/pulse_accum_chk.sv
module pulse_accum_chk
  import pacc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [7:0]        ctrlQ,
  input logic [CNT_W-1:0]  cntQ,
  input logic              ovfFlag,
  input logic              inFlag
);
  logic cntWrite;
  assign cntWrite = wrEn && (addr == ADDR_CNT);

  // R1
  ctrl_msb_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[7] == 1'b0);

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[BIT_EN] && !cntWrite) |=> $stable(cntQ));

  // R3
  disabled_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[BIT_EN] |=> !$rose(inFlag) && !$rose(ovfFlag));

  // R10
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> cntQ == $past(wrData));

  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(cntQ) == {CNT_W{1'b1}}) && (cntQ == '0));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (cntQ == $past(cntQ)) || (cntQ == CNT_W'($past(cntQ) + 1'b1)));
endmodule

bind pulse_accum pulse_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .ctrlQ   (ctrlQ),
  .cntQ    (cntQ),
  .ovfFlag (ovfFlag),
  .inFlag  (inFlag)
);

// File: tb/sim_pulse_accum.sv
module sim_pulse_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        ovfIrq;
  logic        edgeIrq;

  int vectors = 0;
  int miscompares = 0;

  pulse_accum u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ovfIrq(ovfIrq), .edgeIrq(edgeIrq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinPulse();
    pinIn = 1'b1; waitCyc(6);
    pinIn = 1'b0; waitCyc(6);
  endtask

  task automatic testReset();
    logic [15:0] v;
    readReg(2'd0, v); check("R2 ctrl", v, 16'h0);
    readReg(2'd1, v); check("R2 count", v, 16'h0);
    readReg(2'd2, v); check("R2 flags", v, 16'h0);
    check("R2 irqs", {14'h0, ovfIrq, edgeIrq}, 16'h0);
  endtask

  task automatic testDisabled();
    logic [15:0] v;
    busWrite(2'd0, 16'h008C);
    readReg(2'd0, v); check("R1 ctrl readback", v, 16'h000C);
    pinPulse(); pinPulse();
    readReg(2'd1, v); check("R3 count held", v, 16'h0);
    readReg(2'd2, v); check("R3 no flags", v, 16'h0);
  endtask

  task automatic testEventFall();
    logic [15:0] v;
    busWrite(2'd0, 16'h004C);
    pinIn = 1'b1; waitCyc(6);
    readReg(2'd1, v); check("R4 rise ignored", v, 16'h0);
    pinIn = 1'b0; waitCyc(6);
    pinPulse(); pinPulse();
    readReg(2'd1, v); check("R4 falls counted", v, 16'd3);
    readReg(2'd2, v); check("R4 input flag", v, 16'h0002);
    busWrite(2'd2, 16'h0003);
    readReg(2'd2, v); check("R9 clear", v, 16'h0);
  endtask

  task automatic testEventRise();
    logic [15:0] v;
    busWrite(2'd1, 16'h0);
    busWrite(2'd0, 16'h0050);
    pinIn = 1'b1; waitCyc(6);
    readReg(2'd1, v); check("R5 rise counted", v, 16'd1);
    pinIn = 1'b0; waitCyc(6);
    readReg(2'd1, v); check("R5 fall ignored", v, 16'd1);
    pinPulse();
    readReg(2'd1, v); check("R5 total", v, 16'd2);
  endtask

  task automatic testOverflow();
    logic [15:0] v;
    busWrite(2'd0, 16'h0042);
    busWrite(2'd1, 16'hFFFE);
    busWrite(2'd2, 16'h0003);
    pinPulse(); pinPulse();
    readReg(2'd1, v); check("R8 wrapped", v, 16'h0);
    readReg(2'd2, v); check("R8 flags", v, 16'h0003);
    check("R8 ovfIrq", {15'h0, ovfIrq}, 16'h1);
    check("R8 edgeIrq masked", {15'h0, edgeIrq}, 16'h0);
    busWrite(2'd2, 16'h0000);
    readReg(2'd2, v); check("R9 zero write keeps", v, 16'h0003);
    busWrite(2'd2, 16'h0001);
    readReg(2'd2, v); check("R9 clear ovf only", v, 16'h0002);
    check("R8 ovfIrq low", {15'h0, ovfIrq}, 16'h0);
    busWrite(2'd0, 16'h0043);
    check("R8 edgeIrq", {15'h0, edgeIrq}, 16'h1);
    busWrite(2'd2, 16'h0002);
    readReg(2'd2, v); check("R9 clear input", v, 16'h0);
  endtask

  task automatic testGatedHigh();
    logic [15:0] a, b;
    pinIn = 1'b1; waitCyc(6);
    busWrite(2'd2, 16'h0003);
    busWrite(2'd0, 16'h0060);
    waitCyc(5);
    readReg(2'd1, a); waitCyc(640); readReg(2'd1, b);
    check("R6 high window", b - a, 16'd10);
    pinIn = 1'b0; waitCyc(6);
    readReg(2'd2, a); check("R6 trailing fall flag", a, 16'h0002);
    readReg(2'd1, a); waitCyc(640); readReg(2'd1, b);
    check("R6 low window", b - a, 16'd0);
  endtask

  task automatic testGatedLow();
    logic [15:0] a, b;
    busWrite(2'd2, 16'h0003);
    busWrite(2'd0, 16'h0070);
    waitCyc(5);
    readReg(2'd1, a); waitCyc(640); readReg(2'd1, b);
    check("R7 low window", b - a, 16'd10);
    readReg(2'd2, a); check("R7 no flag yet", a, 16'h0);
    pinIn = 1'b1; waitCyc(6);
    readReg(2'd2, a); check("R7 trailing rise flag", a, 16'h0002);
    readReg(2'd1, a); waitCyc(640); readReg(2'd1, b);
    check("R7 high window", b - a, 16'd0);
  endtask

  task automatic testRestart();
    logic [15:0] c, v;
    busWrite(2'd0, 16'h0040);
    waitCyc(3);
    readReg(2'd1, c);
    busWrite(2'd0, 16'h0060);
    waitCyc(63);
    readReg(2'd1, v); check("R11 no early tick", v, c);
    waitCyc(1);
    readReg(2'd1, v); check("R11 first tick", v, c + 16'd1);
    waitCyc(63);
    busWrite(2'd1, 16'h1234);
    readReg(2'd1, v); check("R10 write beats tick", v, 16'h1234);
    waitCyc(63);
    readReg(2'd1, v); check("R11 period held", v, 16'h1234);
    waitCyc(1);
    readReg(2'd1, v); check("R11 next tick", v, 16'h1235);
  endtask

  task automatic testDisableLate();
    logic [15:0] a, b;
    busWrite(2'd0, 16'h0000);
    readReg(2'd1, a);
    pinPulse(); waitCyc(200);
    readReg(2'd1, b); check("R3 disabled after use", b, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testEventFall();
    testEventRise();
    testOverflow();
    testGatedHigh();
    testGatedLow();
    testRestart();
    testDisableLate();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule